// File: doc/BRIEF.md
# Speculative Line Holding Buffer

This block sits beside the memory-side controller of a shared cache level and keeps the cache lines that speculative loads fetched. Each line is kept in an entry selected by the requesting core and by a slot number. The slot is built from the load-queue position of the access and from which half of a line-crossing access it serves. A speculative load that later turns safe issues an expose. If the line is still held, the block answers it from its own storage without going to memory. If not, the expose turns into an ordinary memory read.

Requests arrive one per cycle on the request port, tagged with a two-bit kind. Plain and speculative reads are forwarded to the memory request port one cycle later. The memory returns each line on the response port with the original tags. Lines returned for speculative reads are written into their entry. Whenever a plain read or an expose names a line, every held copy of that line in any core's entries is dropped, so no stale copy can be exposed later. Two counters count exposes served from the buffer and exposes sent to memory.

Top module: `spec_line_buffer`

## Requirements
- R1: After reset, no entry holds a line, `mem_req_valid` and `resp_valid` are low, and both expose counters read zero.
- R2: `req_kind` is encoded as 0 = plain read, 1 = speculative read, 2 = expose. Kind 3 raises `req_illegal` in the same cycle, and the request is dropped: it causes no memory request, no response, no buffer change and no counter change.
- R3: The entry for a request is core `req_core`, slot 2*`req_lq` + `req_upper`. An all-ones `req_lq` marks a request without a load slot (a write). A speculative read or expose that carries that marker, or an `req_lq` at or above the load-queue depth, raises `req_illegal` and is dropped. A plain read that carries the marker is legal.
- R4: A legal plain read appears on the memory request port in the next cycle with `mem_req_spec` = 0 and the request's address and tags. In the same edge it empties every entry, in all cores, that holds that address.
- R5: A legal speculative read appears on the memory request port in the next cycle with `mem_req_spec` = 1. It leaves every entry unchanged.
- R6: A memory response with `mem_rsp_spec` = 1 writes its address and line into the entry named by its core, `mem_rsp_lq` and `mem_rsp_upper`, and marks that entry as holding a line. A response with `mem_rsp_spec` = 0 changes no entry.
- R7: An expose whose own entry holds the same address is a hit. In the next cycle `resp_valid` is high with the held line and tags, and `mem_req_valid` stays low. In the same edge every entry holding that address, including the hit entry, is emptied.
- R8: An expose that misses empties every entry holding its address. It is forwarded to memory in the next cycle as a plain read (`mem_req_spec` = 0).
- R9: `expose_hits` and `expose_misses` each increase by one per legal expose hit or miss, visible in the next cycle. They stop at their all-ones value.
- R10: If a fill and an emptying request target the same entry in the same cycle, the fill wins: the entry holds the new line afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 plain, 1 speculative, 2 expose |
| req_core | input | CORE_W | Requesting core |
| req_lq | input | LQ_W | Load-queue position; all ones = no slot |
| req_upper | input | 1 | Second half of a line-crossing access |
| req_addr | input | ADDR_W | Line address |
| req_illegal | output | 1 | Current request is illegal and dropped |
| mem_req_valid | output | 1 | Memory read issued |
| mem_req_spec | output | 1 | Memory read is speculative |
| mem_req_core | output | CORE_W | Core tag of the memory read |
| mem_req_lq | output | LQ_W | Load-queue tag of the memory read |
| mem_req_upper | output | 1 | Half tag of the memory read |
| mem_req_addr | output | ADDR_W | Line address of the memory read |
| mem_rsp_valid | input | 1 | Memory line returned |
| mem_rsp_spec | input | 1 | Returned line belongs to a speculative read |
| mem_rsp_core | input | CORE_W | Core tag of the returned line |
| mem_rsp_lq | input | LQ_W | Load-queue tag of the returned line |
| mem_rsp_upper | input | 1 | Half tag of the returned line |
| mem_rsp_addr | input | ADDR_W | Address of the returned line |
| mem_rsp_data | input | LINE_W | Returned line data |
| resp_valid | output | 1 | Expose served from the buffer |
| resp_core | output | CORE_W | Core of the served expose |
| resp_lq | output | LQ_W | Load-queue tag of the served expose |
| resp_upper | output | 1 | Half tag of the served expose |
| resp_addr | output | ADDR_W | Address of the served line |
| resp_data | output | LINE_W | Held line data |
| expose_hits | output | CNT_W | Exposes served from the buffer |
| expose_misses | output | CNT_W | Exposes sent to memory |

## Verification
An entry whose held-flag, address or data is wrong can only show up through an expose. The first expose to that entry shows it in the very next cycle: a hit that should have been a miss appears as `resp_valid` without a memory read, a wrong line appears in `resp_data`, and a lost line appears as an unexpected forwarded read with the miss counter moving. The sweeps therefore fill every core and slot pair, then expose every pair. Fills use both unique and shared addresses, so the slot formula and the all-core emptying are both seen at the ports. A same-cycle fill against an emptying read exercises R10.

// File: rtl/slb_pkg.sv
package slb_pkg;
   typedef enum logic [1:0] {
      SLB_PLAIN  = 2'd0,
      SLB_SPEC   = 2'd1,
      SLB_EXPOSE = 2'd2
   } slb_kind_e;
endpackage

// File: rtl/slb_decode.sv
module slb_decode #(
   parameter int NUM_CORES = 8,
   parameter int LQ_DEPTH  = 33,
   parameter bit NEED_SLOT = 1'b0,
   localparam int NUM_SLOTS = 2 * LQ_DEPTH,
   localparam int ENTRIES   = NUM_CORES * NUM_SLOTS,
   localparam int CORE_W    = $clog2(NUM_CORES),
   localparam int LQ_W      = $clog2(LQ_DEPTH + 1),
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              valid,
   input  logic [1:0]        kind,
   input  logic [CORE_W-1:0] core,
   input  logic [LQ_W-1:0]   lq,
   input  logic              upper,
   output logic              legal,
   output logic              slot_ok,
   output logic [IDX_W-1:0]  idx
);
   import slb_pkg::*;

   localparam logic [LQ_W-1:0] NO_LQ = '1;

   logic kind_ok;
   logic core_ok;
   logic lq_ok;

   always_comb begin
      kind_ok = (kind == SLB_PLAIN) || (kind == SLB_SPEC) || (kind == SLB_EXPOSE);
      core_ok = int'(core) < NUM_CORES;
      lq_ok   = (lq != NO_LQ) && (int'(lq) < LQ_DEPTH);
      slot_ok = core_ok && lq_ok;
      if (NEED_SLOT || kind != SLB_PLAIN)
         legal = valid && kind_ok && slot_ok;
      else
         legal = valid && kind_ok && core_ok;
      if (slot_ok)
         idx = IDX_W'(int'(core) * NUM_SLOTS + 2 * int'(lq) + int'(upper));
      else
         idx = '0;
   end
endmodule

// File: rtl/slb_store.sv
module slb_store #(
   parameter int ENTRIES = 528,
   parameter int ADDR_W  = 32,
   parameter int LINE_W  = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [LINE_W-1:0] fill_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LINE_W-1:0] rd_data
);
   logic [ENTRIES-1:0]             ent_vld;
   logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
   logic [ENTRIES-1:0][LINE_W-1:0] ent_data;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic fill_here;
      logic clr_here;
      assign fill_here = fill_en && (int'(fill_idx) == e);
      assign clr_here  = clr_en && ent_vld[e] && (ent_addr[e] == clr_addr);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[e]  <= 1'b0;
            ent_addr[e] <= '0;
         end else if (fill_here) begin
            ent_vld[e]  <= 1'b1;
            ent_addr[e] <= fill_addr;
         end else if (clr_here) begin
            ent_vld[e]  <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_here)
            ent_data[e] <= fill_data;
      end
   end

   always_comb begin
      if (int'(rd_idx) < ENTRIES) begin
         rd_vld  = ent_vld[rd_idx];
         rd_addr = ent_addr[rd_idx];
         rd_data = ent_data[rd_idx];
      end else begin
         rd_vld  = 1'b0;
         rd_addr = '0;
         rd_data = '0;
      end
   end

   // R6 / R10: a fill always leaves its entry holding a line
   p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> ent_vld[$past(fill_idx)]);

   // R4: an emptying request leaves the entry read next holding no line of that address
   p_clear_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !fill_en && rd_idx == $past(rd_idx)) |=>
         !(rd_vld && rd_addr == $past(clr_addr)) || !$stable(rd_idx));
endmodule

// File: rtl/slb_event_ctr.sv
module slb_event_ctr #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)
            count <= '0;
         else if (inc && count != TOP)
            count <= count + 1'b1;
      end

      // R9: count steps by one, or holds at its ceiling
      p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
         inc |=> (count == $past(count) + 1'b1) || ($past(count) == TOP && count == TOP));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)
            count <= '0;
         else if (inc)
            count <= count + 1'b1;
      end

      p_count_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         inc |=> count == $past(count) + 1'b1);
   end

   p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/spec_line_buffer.sv
module spec_line_buffer #(
   parameter int NUM_CORES = 8,
   parameter int LQ_DEPTH  = 33,
   parameter int ADDR_W    = 32,
   parameter int LINE_W    = 64,
   parameter int CNT_W     = 32,
   parameter bit CNT_SAT   = 1'b1,
   localparam int NUM_SLOTS = 2 * LQ_DEPTH,
   localparam int ENTRIES   = NUM_CORES * NUM_SLOTS,
   localparam int CORE_W    = $clog2(NUM_CORES),
   localparam int LQ_W      = $clog2(LQ_DEPTH + 1),
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [CORE_W-1:0] req_core,
   input  logic [LQ_W-1:0]   req_lq,
   input  logic              req_upper,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_illegal,
   output logic              mem_req_valid,
   output logic              mem_req_spec,
   output logic [CORE_W-1:0] mem_req_core,
   output logic [LQ_W-1:0]   mem_req_lq,
   output logic              mem_req_upper,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_spec,
   input  logic [CORE_W-1:0] mem_rsp_core,
   input  logic [LQ_W-1:0]   mem_rsp_lq,
   input  logic              mem_rsp_upper,
   input  logic [ADDR_W-1:0] mem_rsp_addr,
   input  logic [LINE_W-1:0] mem_rsp_data,
   output logic              resp_valid,
   output logic [CORE_W-1:0] resp_core,
   output logic [LQ_W-1:0]   resp_lq,
   output logic              resp_upper,
   output logic [ADDR_W-1:0] resp_addr,
   output logic [LINE_W-1:0] resp_data,
   output logic [CNT_W-1:0]  expose_hits,
   output logic [CNT_W-1:0]  expose_misses
);
   import slb_pkg::*;

   if (NUM_CORES < 2 || LQ_DEPTH < 1 || ADDR_W < 1 || LINE_W < 1 || CNT_W < 1)
   begin : g_bad_param
      $error("spec_line_buffer: parameter out of range");
   end

   // request decode
   logic             req_go;
   logic             req_slot_ok;
   logic [IDX_W-1:0] req_idx;
   logic             k_plain, k_spec, k_expose;

   slb_decode #(.NUM_CORES(NUM_CORES), .LQ_DEPTH(LQ_DEPTH), .NEED_SLOT(1'b0)) i_req_dec (
      .valid   (req_valid),
      .kind    (req_kind),
      .core    (req_core),
      .lq      (req_lq),
      .upper   (req_upper),
      .legal   (req_go),
      .slot_ok (req_slot_ok),
      .idx     (req_idx)
   );

   assign k_plain     = req_kind == SLB_PLAIN;
   assign k_spec      = req_kind == SLB_SPEC;
   assign k_expose    = req_kind == SLB_EXPOSE;
   assign req_illegal = req_valid && !req_go;

   // fill decode
   logic             fill_go;
   logic             fill_slot_ok;
   logic [IDX_W-1:0] fill_idx;

   slb_decode #(.NUM_CORES(NUM_CORES), .LQ_DEPTH(LQ_DEPTH), .NEED_SLOT(1'b1)) i_fill_dec (
      .valid   (mem_rsp_valid && mem_rsp_spec),
      .kind    (SLB_SPEC),
      .core    (mem_rsp_core),
      .lq      (mem_rsp_lq),
      .upper   (mem_rsp_upper),
      .legal   (fill_go),
      .slot_ok (fill_slot_ok),
      .idx     (fill_idx)
   );

   // storage
   logic              rd_vld;
   logic [ADDR_W-1:0] rd_addr;
   logic [LINE_W-1:0] rd_data;
   logic              clr_en;
   logic              hit;
   logic              miss;

   assign clr_en = req_go && !k_spec;
   assign hit    = req_go && k_expose && req_slot_ok && rd_vld && (rd_addr == req_addr);
   assign miss   = req_go && k_expose && !hit;

   slb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en    (clr_en),
      .clr_addr  (req_addr),
      .fill_en   (fill_go),
      .fill_idx  (fill_idx),
      .fill_addr (mem_rsp_addr),
      .fill_data (mem_rsp_data),
      .rd_idx    (req_idx),
      .rd_vld    (rd_vld),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   // output registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req_valid <= 1'b0;
         mem_req_spec  <= 1'b0;
         mem_req_core  <= '0;
         mem_req_lq    <= '0;
         mem_req_upper <= 1'b0;
         mem_req_addr  <= '0;
         resp_valid    <= 1'b0;
         resp_core     <= '0;
         resp_lq       <= '0;
         resp_upper    <= 1'b0;
         resp_addr     <= '0;
         resp_data     <= '0;
      end else begin
         mem_req_valid <= req_go && !hit;
         resp_valid    <= hit;
         if (req_go && !hit) begin
            mem_req_spec  <= k_spec;
            mem_req_core  <= req_core;
            mem_req_lq    <= req_lq;
            mem_req_upper <= req_upper;
            mem_req_addr  <= req_addr;
         end
         if (hit) begin
            resp_core  <= req_core;
            resp_lq    <= req_lq;
            resp_upper <= req_upper;
            resp_addr  <= req_addr;
            resp_data  <= rd_data;
         end
      end
   end

   // counters
   slb_event_ctr #(.CNT_W(CNT_W), .SATURATE(CNT_SAT)) i_hit_ctr (
      .clk (clk), .rst_n (rst_n), .inc (hit), .count (expose_hits)
   );
   slb_event_ctr #(.CNT_W(CNT_W), .SATURATE(CNT_SAT)) i_miss_ctr (
      .clk (clk), .rst_n (rst_n), .inc (miss), .count (expose_misses)
   );

   // R7: a buffered answer never comes with a memory read
   p_hit_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !mem_req_valid);

   // R2 / R3: illegal requests leave no trace on the outputs
   p_drop_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_illegal |=> !mem_req_valid && !resp_valid);

   // R5: speculative reads are tagged speculative towards memory
   p_spec_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_go && k_spec) |=> mem_req_valid && mem_req_spec);

   // R8: expose misses go out as plain reads
   p_miss_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> mem_req_valid && !mem_req_spec);

   // R7: a hit returns the requested address
   p_hit_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> resp_valid && resp_addr == $past(req_addr));
endmodule

// File: tb/test_spec_line_buffer.sv
module test_spec_line_buffer;
   localparam int NC = 2;
   localparam int LQD = 3;
   localparam int NS = 2 * LQD;
   localparam int NE = NC * NS;
   localparam int AW = 16;
   localparam int LW = 32;
   localparam int CW = 4;
   localparam int CMAX = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic          req_core = '0;
   logic [1:0]    req_lq = '0;
   logic          req_upper = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_illegal;
   logic          mem_req_valid, mem_req_spec, mem_req_core, mem_req_upper;
   logic [1:0]    mem_req_lq;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0, mem_rsp_spec = 1'b0, mem_rsp_core = 1'b0;
   logic [1:0]    mem_rsp_lq = '0;
   logic          mem_rsp_upper = 1'b0;
   logic [AW-1:0] mem_rsp_addr = '0;
   logic [LW-1:0] mem_rsp_data = '0;
   logic          resp_valid, resp_core, resp_upper;
   logic [1:0]    resp_lq;
   logic [AW-1:0] resp_addr;
   logic [LW-1:0] resp_data;
   logic [CW-1:0] expose_hits, expose_misses;

   spec_line_buffer #(.NUM_CORES(NC), .LQ_DEPTH(LQD), .ADDR_W(AW), .LINE_W(LW),
                      .CNT_W(CW), .CNT_SAT(1'b1)) i_spec_line_buffer (
      .clk, .rst_n, .req_valid, .req_kind, .req_core, .req_lq, .req_upper, .req_addr,
      .req_illegal, .mem_req_valid, .mem_req_spec, .mem_req_core, .mem_req_lq,
      .mem_req_upper, .mem_req_addr, .mem_rsp_valid, .mem_rsp_spec, .mem_rsp_core,
      .mem_rsp_lq, .mem_rsp_upper, .mem_rsp_addr, .mem_rsp_data, .resp_valid,
      .resp_core, .resp_lq, .resp_upper, .resp_addr, .resp_data, .expose_hits,
      .expose_misses
   );

   always #10 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference model
   bit            mv [NE];
   logic [AW-1:0] ma [NE];
   logic [LW-1:0] md [NE];
   int            n_hit = 0;
   int            n_miss = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int slot_of(input int c, input int lq, input int up);
      return c * NS + 2 * lq + up;
   endfunction

   // one clock cycle with an optional request and an optional memory response
   task automatic cycle(input bit rq, input int kind, input int c, input int lq,
                        input int up, input int addr, input bit rs, input bit rspec,
                        input int rc, input int rlq, input int rup, input int raddr,
                        input int rdata);
      bit legal, hit, slot_ok;
      int ix;
      logic [LW-1:0] hdata;
      string tg;
      slot_ok = (lq != 3) && (lq < LQD);
      legal = rq && kind <= 2 && (kind == 0 || slot_ok);
      ix = slot_ok ? slot_of(c, lq, up) : 0;
      hit = legal && kind == 2 && mv[ix] && ma[ix] == AW'(addr);
      hdata = md[ix];
      req_valid = rq; req_kind = 2'(kind); req_core = 1'(c); req_lq = 2'(lq);
      req_upper = 1'(up); req_addr = AW'(addr);
      mem_rsp_valid = rs; mem_rsp_spec = rspec; mem_rsp_core = 1'(rc);
      mem_rsp_lq = 2'(rlq); mem_rsp_upper = 1'(rup); mem_rsp_addr = AW'(raddr);
      mem_rsp_data = LW'(rdata);
      #1;
      chk(kind == 3 ? "R2 illegal kind" : "R3 illegal flag", req_illegal, rq && !legal);
      @(posedge clk);
      @(negedge clk);
      tg = kind == 0 ? "R4 plain fwd" : kind == 1 ? "R5 spec fwd" : "R8 expose fwd";
      chk(tg, mem_req_valid, legal && !hit);
      if (legal && !hit) begin
         chk({tg, " spec"}, mem_req_spec, kind == 1);
         chk({tg, " addr"}, mem_req_addr, AW'(addr));
         chk({tg, " tags"}, {mem_req_core, mem_req_lq, mem_req_upper},
             {1'(c), 2'(lq), 1'(up)});
      end
      chk("R7 resp valid", resp_valid, hit);
      if (hit) begin
         chk("R7 resp data", resp_data, hdata);
         chk("R7 resp tags", {resp_core, resp_lq, resp_upper}, {1'(c), 2'(lq), 1'(up)});
      end
      // model update: emptying first, fill wins (R10)
      if (legal && kind != 1)
         for (int e = 0; e < NE; e++)
            if (mv[e] && ma[e] == AW'(addr)) mv[e] = 1'b0;
      if (hit && n_hit < CMAX) n_hit++;
      if (legal && kind == 2 && !hit && n_miss < CMAX) n_miss++;
      if (rs && rspec) begin
         mv[slot_of(rc, rlq, rup)] = 1'b1;
         ma[slot_of(rc, rlq, rup)] = AW'(raddr);
         md[slot_of(rc, rlq, rup)] = LW'(rdata);
      end
      chk("R9 hit count", expose_hits, n_hit);
      chk("R9 miss count", expose_misses, n_miss);
      req_valid = 1'b0; mem_rsp_valid = 1'b0;
   endtask

   task automatic req(input int kind, input int c, input int lq, input int up, input int addr);
      cycle(1'b1, kind, c, lq, up, addr, 1'b0, 1'b0, 0, 0, 0, 0, 0);
   endtask

   task automatic fill(input int c, input int lq, input int up, input int addr, input int data);
      cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 1'b1, c, lq, up, addr, data);
   endtask

   initial begin
      for (int e = 0; e < NE; e++) begin mv[e] = 0; ma[e] = '0; md[e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 mem_req_valid", mem_req_valid, 0);
      chk("R1 resp_valid", resp_valid, 0);
      chk("R1 hits", expose_hits, 0);
      chk("R1 misses", expose_misses, 0);
      for (int c = 0; c < NC; c++)
         for (int l = 0; l < LQD; l++)
            for (int u = 0; u < 2; u++)
               req(2, c, l, u, 0);               // R1: empty buffer, every expose misses (R8)

      // R6 / R3 / R7: unique lines in every slot, exposed once (hit) and again (miss)
      for (int c = 0; c < NC; c++)
         for (int l = 0; l < LQD; l++)
            for (int u = 0; u < 2; u++)
               fill(c, l, u, 'h100 + slot_of(c, l, u) * 8, 'hA5000000 + slot_of(c, l, u) * 'h111);
      req(2, 0, 1, 0, 'h100 + slot_of(0, 1, 1) * 8);   // R3: neighbouring slot, wrong address
      for (int c = 0; c < NC; c++)
         for (int l = 0; l < LQD; l++)
            for (int u = 0; u < 2; u++) begin
               req(2, c, l, u, 'h100 + slot_of(c, l, u) * 8);
               req(2, c, l, u, 'h100 + slot_of(c, l, u) * 8);
            end

      // R4 / R5: shared address in all slots
      for (int e = 0; e < NE; e++) fill(e / NS, (e % NS) / 2, e % 2, 'h55, 'h3C00 + e);
      req(2, 1, 2, 1, 'h56);                     // R8 miss on other address
      req(1, 0, 0, 0, 'h55);                     // R5 leaves buffer alone
      req(2, 1, 2, 1, 'h55);                     // R7 hit, empties all cores
      for (int e = 0; e < NE; e++) req(2, e / NS, (e % NS) / 2, e % 2, 'h55);
      for (int e = 0; e < NE; e++) fill(e / NS, (e % NS) / 2, e % 2, 'h77, 'h7700 + e);
      req(0, 1, 3, 0, 'h77);                     // R4 plain read with no slot (write marker)
      for (int e = 0; e < NE; e++) req(2, e / NS, (e % NS) / 2, e % 2, 'h77);

      // R6: non-speculative response changes nothing
      cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 2, 0, 'h88, 'h1234);
      req(2, 0, 2, 0, 'h88);

      // R10: fill and plain read of the same line in one cycle
      fill(1, 0, 0, 'h99, 'hBEEF);
      cycle(1'b1, 0, 0, 1, 1, 'h99, 1'b1, 1'b1, 0, 0, 0, 'h99, 'hCAFE);
      req(2, 0, 0, 0, 'h99);                     // R10 fill won: hit with new line
      fill(1, 1, 0, 'h99, 'hBEEF);
      cycle(1'b1, 2, 1, 1, 0, 'h99, 1'b1, 1'b1, 1, 1, 0, 'h99, 'hF00D);
      req(2, 1, 1, 0, 'h99);                     // R10 expose-hit emptying loses to fill

      // R2 / R3: illegal requests dropped
      fill(0, 2, 1, 'h44, 'h4444);
      req(3, 0, 2, 1, 'h44);
      req(2, 0, 3, 1, 'h44);
      req(1, 0, 3, 0, 'h44);
      req(2, 0, 2, 1, 'h44);                     // still held: hit proves nothing changed
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule